// File: doc/BRIEF.md
# Subnormal-Aware Operand Steering Controller

This block sits in front of a single-precision multiply pipeline and decides, pair by pair, which of two execution paths receives the operands. A fast path accepts only operands that are not subnormal. A slower generic path accepts anything, but it takes a new pair only once every few cycles because it inspects exponents before it computes. The controller classifies both operands of each incoming pair. It runs in a fast mode until a subnormal shows up. It then pays a fixed switch penalty, moves to generic mode, and stays there until a run of pairs free of subnormals has gone by.

Operands arrive on a valid/ready stream and leave through a one-entry output register on a second valid/ready stream. Input back-pressure comes from three sources: a full output register, the switch penalty, and the forced gap after each generic-path issue. In fast mode, `in_ready` also depends on the pair currently presented. A pair with a subnormal operand is never accepted there. It must stay on the inputs with `in_valid` high until the switch completes. A sender must hold a pair stable while `in_valid` is high and `in_ready` is low. The output side holds its item stable while `out_valid` is high and `out_ready` is low.

Top module: `subn_mode_ctrl`

## Requirements
- R1: Each operand gets a 2-bit class flag. 2'b10 means subnormal (exponent field all zeros, fraction nonzero). 2'b01 means zero (exponent and fraction all zeros). 2'b00 covers every other value, including infinity and NaN.
- R2: In fast mode, a pair is accepted only when neither operand is subnormal. It leaves with `out_generic` = 0 and is accepted on the first cycle it is presented, provided the output register is free.
- R3: A pair with a subnormal operand presented in fast mode raises `switch_count` by one. It is held for PENALTY cycles after the detection cycle and is accepted in generic mode PENALTY+1 cycles after it was first presented, provided the output register is free.
- R4: In generic mode, every pair leaves with `out_generic` = 1. After each generic acceptance that does not end the mode, `in_ready` stays low for GEN_RATE-1 cycles, so acceptances are GEN_RATE cycles apart.
- R5: The QUIET_OPS-th consecutive generic-mode pair without a subnormal is still tagged generic. It returns the block to fast mode with no wait, and the next pair takes the fast path.
- R6: A subnormal pair accepted in generic mode restarts the quiet run and adds no switch or penalty. With one subnormal every QUIET_OPS pairs, the block never leaves generic mode.
- R7: `stall_count` equals PENALTY per switch plus GEN_RATE-1 per generic acceptance that does not end the mode.
- R8: Output pairs appear in input order, with none lost or duplicated, and stay stable while `out_valid` is high and `out_ready` is low.
- R9: A synchronous active-high reset selects fast mode, empties the output register and clears both counters.
- R10: `mode_generic` is high exactly while the block is in generic mode, after any penalty has ended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input pair valid |
| in_ready | output | 1 | Input pair accepted when high with in_valid |
| in_a | input | 32 | First operand |
| in_b | input | 32 | Second operand |
| out_valid | output | 1 | Output pair valid |
| out_ready | input | 1 | Downstream takes the output pair |
| out_a | output | 32 | First operand, issued |
| out_b | output | 32 | Second operand, issued |
| out_generic | output | 1 | 1: generic path, 0: fast path |
| out_a_cls | output | 2 | Class flag of out_a |
| out_b_cls | output | 2 | Class flag of out_b |
| mode_generic | output | 1 | Block is in generic mode |
| switch_count | output | 16 | Number of fast-to-generic switches |
| stall_count | output | 16 | Penalty plus generic-wait cycles |

## Verification
The hardest case to reach from the ports is the edge of the quiet run. In one case a subnormal lands exactly on the last pair before the timeout would expire. In the other it lands one pair later and forces a fresh switch. The stimulus sweeps the spacing of subnormals over a stream of pairs and includes spacings of QUIET_OPS and QUIET_OPS+1. It alternates the subnormal between the two operands and mixes in zeros, infinities and NaNs. Selected spacings are repeated with a pseudo-random `out_ready`, so that generic waits and penalties overlap output back-pressure.

// File: rtl/subn_pkg.sv
package subn_pkg;
  typedef enum logic [1:0] {
    CLS_NORMAL = 2'b00,
    CLS_ZERO   = 2'b01,
    CLS_SUBN   = 2'b10
  } opcls_e;

  typedef enum logic [1:0] {
    M_FAST    = 2'b00,
    M_PENALTY = 2'b01,
    M_GENERIC = 2'b10
  } mode_e;
endpackage

// File: rtl/subn_classify.sv
module subn_classify
  import subn_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int OP_W  = 1 + EXP_W + FRAC_W
) (
  input  logic [OP_W-1:0] op,
  output opcls_e          cls
);
  logic [EXP_W-1:0]  expf;
  logic [FRAC_W-1:0] frac;

  assign expf = op[OP_W-2 -: EXP_W];
  assign frac = op[FRAC_W-1:0];

  always_comb begin
    if (expf != '0)      cls = CLS_NORMAL;
    else if (frac == '0) cls = CLS_ZERO;
    else                 cls = CLS_SUBN;
  end
endmodule

// File: rtl/subn_mode_fsm.sv
module subn_mode_fsm
  import subn_pkg::*;
#(
  parameter int PENALTY   = 8,
  parameter int GEN_RATE  = 2,
  parameter int QUIET_OPS = 16,
  parameter int CNT_W     = 16,
  localparam int PEN_W = $clog2(PENALTY + 1),
  localparam int GAP_W = $clog2(GEN_RATE + 1),
  localparam int Q_W   = $clog2(QUIET_OPS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             any_sub,
  input  logic             slot_free,
  output logic             in_ready,
  output logic             issue_gen,
  output logic             mode_generic,
  output logic [CNT_W-1:0] switch_count,
  output logic [CNT_W-1:0] stall_count
);
  mode_e            state;
  logic [PEN_W-1:0] pen_left;
  logic [GAP_W-1:0] gap_left;
  logic [Q_W-1:0]   quiet_run;
  logic             accept;

  always_comb begin
    case (state)
      M_FAST:    in_ready = slot_free && !any_sub;
      M_GENERIC: in_ready = slot_free && (gap_left == '0);
      default:   in_ready = 1'b0;
    endcase
  end

  assign accept       = in_valid && in_ready;
  assign issue_gen    = (state == M_GENERIC);
  assign mode_generic = (state == M_GENERIC);

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= M_FAST;
      pen_left     <= '0;
      gap_left     <= '0;
      quiet_run    <= '0;
      switch_count <= '0;
      stall_count  <= '0;
    end else begin
      case (state)
        M_FAST: begin
          if (in_valid && any_sub) begin
            state        <= M_PENALTY;
            pen_left     <= PEN_W'(PENALTY - 1);
            switch_count <= switch_count + 1'b1;
          end
        end
        M_PENALTY: begin
          stall_count <= stall_count + 1'b1;
          if (pen_left == '0) begin
            state     <= M_GENERIC;
            gap_left  <= '0;
            quiet_run <= '0;
          end else begin
            pen_left <= pen_left - 1'b1;
          end
        end
        M_GENERIC: begin
          if (gap_left != '0) begin
            gap_left    <= gap_left - 1'b1;
            stall_count <= stall_count + 1'b1;
          end
          if (accept) begin
            if (any_sub) begin
              quiet_run <= '0;
              gap_left  <= GAP_W'(GEN_RATE - 1);
            end else if (quiet_run == Q_W'(QUIET_OPS - 1)) begin
              state     <= M_FAST;
              quiet_run <= '0;
            end else begin
              quiet_run <= quiet_run + 1'b1;
              gap_left  <= GAP_W'(GEN_RATE - 1);
            end
          end
        end
        default: state <= M_FAST;
      endcase
    end
  end
endmodule

// File: rtl/subn_out_stage.sv
module subn_out_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] d,
  input  logic         out_ready,
  output logic         out_valid,
  output logic [W-1:0] q,
  output logic         slot_free
);
  assign slot_free = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      q         <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      q         <= d;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/subn_mode_ctrl.sv
module subn_mode_ctrl
  import subn_pkg::*;
#(
  parameter int EXP_W     = 8,
  parameter int FRAC_W    = 23,
  parameter int PENALTY   = 8,
  parameter int GEN_RATE  = 2,
  parameter int QUIET_OPS = 16,
  parameter int CNT_W     = 16,
  localparam int OP_W  = 1 + EXP_W + FRAC_W,
  localparam int PKT_W = 2 * OP_W + 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [OP_W-1:0]  in_a,
  input  logic [OP_W-1:0]  in_b,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [OP_W-1:0]  out_a,
  output logic [OP_W-1:0]  out_b,
  output logic             out_generic,
  output logic [1:0]       out_a_cls,
  output logic [1:0]       out_b_cls,
  output logic             mode_generic,
  output logic [CNT_W-1:0] switch_count,
  output logic [CNT_W-1:0] stall_count
);
  logic [OP_W-1:0]  op_w [2];
  opcls_e           cls_w [2];
  logic             any_sub;
  logic             slot_free;
  logic             issue_gen;
  logic [PKT_W-1:0] pkt_d;
  logic [PKT_W-1:0] pkt_q;

  assign op_w[0] = in_a;
  assign op_w[1] = in_b;

  for (genvar g = 0; g < 2; g++) begin : g_cls
    subn_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
      .op  (op_w[g]),
      .cls (cls_w[g])
    );
  end

  assign any_sub = (cls_w[0] == CLS_SUBN) || (cls_w[1] == CLS_SUBN);

  subn_mode_fsm #(
    .PENALTY(PENALTY), .GEN_RATE(GEN_RATE),
    .QUIET_OPS(QUIET_OPS), .CNT_W(CNT_W)
  ) u_fsm (
    .clk          (clk),
    .rst          (rst),
    .in_valid     (in_valid),
    .any_sub      (any_sub),
    .slot_free    (slot_free),
    .in_ready     (in_ready),
    .issue_gen    (issue_gen),
    .mode_generic (mode_generic),
    .switch_count (switch_count),
    .stall_count  (stall_count)
  );

  assign pkt_d = {issue_gen, cls_w[1], cls_w[0], in_b, in_a};

  subn_out_stage #(.W(PKT_W)) u_out (
    .clk       (clk),
    .rst       (rst),
    .load      (in_valid && in_ready),
    .d         (pkt_d),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .q         (pkt_q),
    .slot_free (slot_free)
  );

  assign out_a       = pkt_q[OP_W-1:0];
  assign out_b       = pkt_q[2*OP_W-1:OP_W];
  assign out_a_cls   = pkt_q[2*OP_W+1:2*OP_W];
  assign out_b_cls   = pkt_q[2*OP_W+3:2*OP_W+2];
  assign out_generic = pkt_q[2*OP_W+4];
endmodule

// File: rtl/subn_mode_ctrl_chk.sv
module subn_mode_ctrl_chk #(
  parameter int EXP_W    = 8,
  parameter int FRAC_W   = 23,
  parameter int GEN_RATE = 2,
  parameter int CNT_W    = 16,
  localparam int OP_W = 1 + EXP_W + FRAC_W
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             in_ready,
  input logic [OP_W-1:0]  in_a,
  input logic [OP_W-1:0]  in_b,
  input logic             out_valid,
  input logic             out_ready,
  input logic [OP_W-1:0]  out_a,
  input logic [OP_W-1:0]  out_b,
  input logic             out_generic,
  input logic [1:0]       out_a_cls,
  input logic [1:0]       out_b_cls,
  input logic             mode_generic,
  input logic [CNT_W-1:0] switch_count,
  input logic [CNT_W-1:0] stall_count
);
  logic in_has_sub;
  assign in_has_sub =
    ((in_a[OP_W-2 -: EXP_W] == '0) && (in_a[FRAC_W-1:0] != '0)) ||
    ((in_b[OP_W-2 -: EXP_W] == '0) && (in_b[FRAC_W-1:0] != '0));

  p_sub_never_fast_r2: assert property (@(posedge clk) disable iff (rst)
    out_valid && (out_a_cls == 2'b10 || out_b_cls == 2'b10) |-> out_generic);

  p_fast_blocks_sub_r2: assert property (@(posedge clk) disable iff (rst)
    in_valid && !mode_generic && in_has_sub |-> !in_ready);

  p_switch_stalls_r3: assert property (@(posedge clk) disable iff (rst)
    (switch_count != $past(switch_count)) |-> !in_ready && !mode_generic);

  p_gen_gap_r4: assert property (@(posedge clk) disable iff (rst)
    (GEN_RATE > 1) && mode_generic && in_valid && in_ready |=> !in_ready || !mode_generic);

  p_stall_only_blocked_r7: assert property (@(posedge clk) disable iff (rst)
    (stall_count != $past(stall_count)) |-> !$past(in_ready));

  p_out_hold_r8: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_a) && $stable(out_b) &&
                                $stable(out_generic) && $stable(out_a_cls) && $stable(out_b_cls));

  p_reset_state_r9: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !out_valid && !mode_generic && switch_count == '0 && stall_count == '0);
endmodule

bind subn_mode_ctrl subn_mode_ctrl_chk #(
  .EXP_W(EXP_W), .FRAC_W(FRAC_W), .GEN_RATE(GEN_RATE), .CNT_W(CNT_W)
) chk_i (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_ready(out_ready),
  .out_a(out_a), .out_b(out_b), .out_generic(out_generic),
  .out_a_cls(out_a_cls), .out_b_cls(out_b_cls), .mode_generic(mode_generic),
  .switch_count(switch_count), .stall_count(stall_count)
);

// File: tb/subn_mode_ctrl_tb.sv
module subn_mode_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int PEN  = 8;
  localparam int RATE = 2;
  localparam int TMO  = 16;
  localparam int MAXN = 64;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_a = '0;
  logic [31:0] in_b = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [31:0] out_a, out_b;
  logic        out_generic;
  logic [1:0]  out_a_cls, out_b_cls;
  logic        mode_generic;
  logic [15:0] switch_count, stall_count;

  int tests = 0;
  int fails = 0;

  int          ka [MAXN];
  int          kb [MAXN];
  logic [31:0] oa [MAXN];
  logic [31:0] ob [MAXN];
  bit          etag [MAXN];
  bit          epen [MAXN];
  bit          egap [MAXN];
  bit          gtag [MAXN];
  int          acc  [MAXN];
  int          exp_sw, exp_st;
  bit          exp_mode;

  always #(CLK_PERIOD/2) clk = ~clk;

  subn_mode_ctrl #(.PENALTY(PEN), .GEN_RATE(RATE), .QUIET_OPS(TMO), .CNT_W(16)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_ready(out_ready),
    .out_a(out_a), .out_b(out_b), .out_generic(out_generic),
    .out_a_cls(out_a_cls), .out_b_cls(out_b_cls), .mode_generic(mode_generic),
    .switch_count(switch_count), .stall_count(stall_count)
  );

  task automatic chk(string req, longint got, longint expv);
    tests++;
    if (got != expv) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, got, expv);
    end
  endtask

  // kind 0 normal, 1 zero, 2 subnormal, 3 infinity/NaN
  function automatic logic [31:0] mk(int kind, int idx);
    case (kind)
      1:       mk = {idx[1], 31'b0};
      2:       mk = {idx[2], 8'h00, 23'(idx * 13 + 1)};
      3:       mk = {1'b0, 8'hff, 23'(idx)};
      default: mk = {idx[0], 8'(8'h40 + idx % 32), 23'(idx * 977 + 5)};
    endcase
  endfunction

  function automatic int cls_of(int kind);
    return (kind == 1) ? 1 : (kind == 2) ? 2 : 0;
  endfunction

  // operand-level model of the steering rules
  task automatic model(int n);
    bit mode = 0;
    int q = 0;
    bit sub;
    exp_sw = 0; exp_st = 0;
    for (int i = 0; i < n; i++) begin
      sub = (ka[i] == 2) || (kb[i] == 2);
      epen[i] = 0; egap[i] = 0;
      if (!mode && sub) begin
        exp_sw++; exp_st += PEN; mode = 1; q = 0; epen[i] = 1;
      end
      etag[i] = mode;
      if (mode) begin
        if (sub) begin q = 0; exp_st += RATE - 1; egap[i] = 1; end
        else if (q == TMO - 1) begin mode = 0; q = 0; end
        else begin q++; exp_st += RATE - 1; egap[i] = 1; end
      end
    end
    exp_mode = mode;
  endtask

  // pattern: spacing p (0 = none), sub_at (single subnormal index or -1)
  task automatic build(int n, int p, int sub_at);
    for (int i = 0; i < n; i++) begin
      ka[i] = (i % 5 == 2) ? 1 : (i % 7 == 3) ? 3 : 0;
      kb[i] = (i % 6 == 4) ? 1 : (i % 9 == 5) ? 3 : 0;
      if ((p > 0 && i % p == 0) || i == sub_at) begin
        if (((p > 0 ? i / p : 0) % 2) == 1) kb[i] = 2;
        else ka[i] = 2;
      end
      oa[i] = mk(ka[i], i);
      ob[i] = mk(kb[i], i + 100);
    end
  endtask

  task automatic run_case(int n, bit bp);
    int tx = 0;
    int rx = 0;
    int cyc = 0;
    bit took;
    logic [15:0] lfsr = 16'hACE1;
    int expd;
    model(n);
    rst = 1; in_valid = 0; out_ready = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    #1;
    chk("R9 out_valid after reset", out_valid, 0);
    chk("R9 counters after reset", {switch_count, stall_count}, 0);
    chk("R10 mode after reset", mode_generic, 0);
    while (rx < n) begin
      out_ready = bp ? (lfsr[0] | lfsr[3]) : 1'b1;
      in_valid  = (tx < n);
      in_a      = oa[(tx < n) ? tx : 0];
      in_b      = ob[(tx < n) ? tx : 0];
      #1;
      if (out_valid && out_ready) begin
        chk("R8 out_a order", out_a, oa[rx]);
        chk("R8 out_b order", out_b, ob[rx]);
        chk("R1 class a", out_a_cls, cls_of(ka[rx]));
        chk("R1 class b", out_b_cls, cls_of(kb[rx]));
        chk("R4 path tag", out_generic, etag[rx]);
        gtag[rx] = out_generic;
        rx++;
      end
      took = in_valid && in_ready;
      if (took) acc[tx] = cyc;
      @(posedge clk);
      if (took) tx++;
      cyc++;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      @(negedge clk);
    end
    in_valid = 0; out_ready = 1;
    repeat (PEN + RATE + 2) @(negedge clk);
    #1;
    chk("R3 switch count", switch_count, exp_sw);
    chk("R7 stall count", stall_count, exp_st);
    chk("R10 final mode", mode_generic, exp_mode);
    if (!bp) begin
      for (int i = 0; i < n; i++) begin
        if (i == 0) expd = epen[0] ? PEN + 1 : 0;
        else expd = epen[i] ? PEN + 2 : (egap[i-1] ? RATE : 1);
        if (epen[i])                chk("R3 accept delay", (i == 0) ? acc[0] : acc[i] - acc[i-1], expd);
        else if (i > 0 && egap[i-1]) chk("R4 generic spacing", acc[i] - acc[i-1], expd);
        else                        chk("R2 fast accept", (i == 0) ? acc[0] : acc[i] - acc[i-1], expd);
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: got 1 expected 0");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    // no subnormals: everything on the fast path
    build(40, 0, -1);
    run_case(40, 0);
    chk("R2 no switch without subnormal", switch_count, 0);

    // single subnormal at pair 3: pairs 3..19 generic, pair 20 fast
    build(40, 0, 3);
    run_case(40, 0);
    chk("R5 last quiet pair still generic", gtag[19], 1);
    chk("R5 next pair back on fast path", gtag[20], 0);
    chk("R3 one switch", switch_count, 1);

    // spacing equal to the timeout keeps generic mode
    build(48, TMO, -1);
    run_case(48, 0);
    chk("R6 restart keeps one switch", switch_count, 1);
    chk("R6 stall total", stall_count, PEN + 48 * (RATE - 1));

    // one beyond the timeout forces a switch per subnormal
    build(48, TMO + 1, -1);
    run_case(48, 0);
    chk("R5 switch per subnormal", switch_count, 3);

    // density sweep
    for (int p = 1; p <= 24; p += 3) begin
      build(48, p, -1);
      run_case(48, 0);
    end

    // back-pressure overlapping waits and penalties
    build(48, 4, -1);
    run_case(48, 1);
    build(48, TMO + 1, -1);
    run_case(48, 1);
    build(48, 9, -1);
    run_case(48, 1);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule